// File: doc/BRIEF.md
# Four-Channel Match-Driven Waveform Timer

This block is a 16-bit up-counter that restarts at zero after a programmable limit. It drives four waveform outputs, each with a set compare value and a clear compare value. The counter advances on a tick chosen from three sources: the clock divided by two, the clock divided by sixteen, or a tick pulse from another timer. A fourth setting stops it. Because each output has its own set and clear points, software can place arbitrary phase-shifted pulse trains on the four pins, for example quadrature pairs or three-phase drive for a motor.

The limit and all eight compare values come in from an external register file. The block copies them into working registers only at the wrap to zero, or when the block is first enabled. Software can therefore rewrite any value in the middle of a period without a glitch. Every compare uses the working copies. Each time the counter wraps from the limit to zero, a sticky interrupt flag is set. The flag is cleared by a write-one pulse and is gated onto the interrupt line by an enable bit.

Top module: `mpwm_timer`

## Requirements
- R1: While running, the count goes from 0 up to the working limit and then returns to 0 on the next tick. One period is therefore limit plus one ticks, and the count never exceeds the working limit.
- R2: The count advances only on the selected tick. Selector 2'b00 ticks every 2 clocks, 2'b01 ticks every 16 clocks, 2'b10 uses the external tick pulse, and 2'b11 stops the count.
- R3: An output goes to 1 on the clock after the count equals that output's working set value.
- R4: An output goes to 0 on the clock after the count equals that output's working clear value. When the set and clear values are equal, the clear takes priority and the output stays 0.
- R5: The working limit, set values and clear values are loaded from the inputs only at the wrap to zero and at the first clock that the enable is high. A change to an input in the middle of a period has no effect until the next wrap.
- R6: The interrupt flag is set on the tick that wraps the count from the limit to zero. It stays set until an `irq_clr` pulse. If a wrap and a clear arrive in the same cycle, the set wins.
- R7: `irq_o` is high exactly when the flag is set and `irq_en` is high.
- R8: While `en` is low, the count is held at 0 and all outputs are low from the next clock onward.
- R9: After reset, the count is 0, all outputs are low and the interrupt flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global run enable |
| tick_sel | input | 2 | Tick source select |
| ext_tick | input | 1 | External tick pulse, one clock wide |
| limit_i | input | 16 | Programmed count limit |
| set_i | input | 64 | Set compare values, channel n in bits 16n+15:16n |
| clr_i | input | 64 | Clear compare values, channel n in bits 16n+15:16n |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| count_o | output | 16 | Current count |
| pwm_o | output | 4 | Waveform outputs |
| irq_flag_o | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench changes the limit and a channel's compare values in the middle of a period. A design without double buffering would cut the period short or move the edge early. One channel has equal set and clear values, and a design that gave priority to the set would produce a one-tick pulse on it. A wrap and a flag clear are driven in the same cycle, and a design that let the clear win would lose that interrupt. The bench also measures the spacing of the divide-by-2 and divide-by-16 ticks, and a prescaler that is off by one shows up as a wrong interval.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int N_OUT_DEF = 4;
    localparam int PRE_W_DEF = 4;

    typedef enum logic [1:0] {
        SRC_DIV2  = 2'b00,
        SRC_DIV16 = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_STOP  = 2'b11
    } tick_src_e;

    typedef struct packed {
        logic run;
        logic wrap;
        logic load;
    } cnt_ctl_t;

    function automatic logic wave_next(logic cur, logic hit_set, logic hit_clr);
        if (hit_clr)      return 1'b0;
        else if (hit_set) return 1'b1;
        else              return cur;
    endfunction

endpackage

// File: rtl/mpwm_tick_gen.sv
module mpwm_tick_gen
    import mpwm_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  tick_src_e sel,
    input  logic      ext_tick,
    output logic      tick
);

    logic [PRE_W-1:0] pre_q;
    logic             raw_tick;

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        unique case (sel)
            SRC_DIV2:  raw_tick = pre_q[0];
            SRC_DIV16: raw_tick = &pre_q;
            SRC_EXT:   raw_tick = ext_tick;
            default:   raw_tick = 1'b0;
        endcase
        tick = run & raw_tick;
    end

endmodule

// File: rtl/mpwm_counter.sv
module mpwm_counter
    import mpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lim_w,
    output cnt_ctl_t         ctl
);

    logic run_q;

    always_comb begin
        ctl.run  = en & run_q;
        ctl.wrap = ctl.run & tick & (cnt == lim_w);
        ctl.load = (en & ~run_q) | ctl.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt   <= '0;
            lim_w <= '0;
        end else begin
            run_q <= en;
            if (ctl.load) lim_w <= limit_i;
            if (!en)           cnt <= '0;
            else if (ctl.wrap) cnt <= '0;
            else if (ctl.run && tick) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
    import mpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] set_i,
    input  logic [CNT_W-1:0] clr_i,
    output logic [CNT_W-1:0] set_w,
    output logic [CNT_W-1:0] clr_w,
    output logic             wave
);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_w <= '0;
            clr_w <= '0;
        end else if (load) begin
            set_w <= set_i;
            clr_w <= clr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) wave <= 1'b0;
        else             wave <= wave_next(wave, cnt == set_w, cnt == clr_w);
    end

endmodule

// File: rtl/mpwm_timer.sv
module mpwm_timer
    import mpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int N_OUT = N_OUT_DEF,
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [1:0]         tick_sel,
    input  logic               ext_tick,
    input  logic [CNT_W-1:0]   limit_i,
    input  logic [N_OUT*CNT_W-1:0] set_i,
    input  logic [N_OUT*CNT_W-1:0] clr_i,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic [CNT_W-1:0]   count_o,
    output logic [N_OUT-1:0]   pwm_o,
    output logic               irq_flag_o,
    output logic               irq_o
);

    localparam int VEC_W = N_OUT * CNT_W;

    cnt_ctl_t         ctl;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_w;
    logic [VEC_W-1:0] set_w_flat;
    logic [VEC_W-1:0] clr_w_flat;
    logic             flag_q;

    mpwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl.run),
        .sel      (tick_src_e'(tick_sel)),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    mpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .limit_i (limit_i),
        .cnt     (cnt),
        .lim_w   (lim_w),
        .ctl     (ctl)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_chan
        mpwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .run   (ctl.run),
            .load  (ctl.load),
            .cnt   (cnt),
            .set_i (set_i[g*CNT_W +: CNT_W]),
            .clr_i (clr_i[g*CNT_W +: CNT_W]),
            .set_w (set_w_flat[g*CNT_W +: CNT_W]),
            .clr_w (clr_w_flat[g*CNT_W +: CNT_W]),
            .wave  (pwm_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (ctl.wrap) flag_q <= 1'b1;
        else if (irq_clr)  flag_q <= 1'b0;
    end

    assign count_o    = cnt;
    assign irq_flag_o = flag_q;
    assign irq_o      = flag_q & irq_en;

endmodule

// File: rtl/mpwm_timer_chk.sv
module mpwm_timer_chk #(
    parameter int CNT_W = 16,
    parameter int N_OUT = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   en,
    input logic [1:0]             tick_sel,
    input logic                   irq_en,
    input logic                   irq_clr,
    input logic [CNT_W-1:0]       count_o,
    input logic [N_OUT-1:0]       pwm_o,
    input logic                   irq_flag_o,
    input logic                   irq_o,
    input logic [CNT_W-1:0]       lim_w,
    input logic [N_OUT*CNT_W-1:0] set_w_flat,
    input logic [N_OUT*CNT_W-1:0] clr_w_flat
);

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
        count_o <= lim_w);

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (en && tick_sel == 2'b11) |=> $stable(count_o));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_flag_o && !irq_clr) |=> irq_flag_o);

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_o);

    a_r7_irq_passes: assert property (@(posedge clk) disable iff (rst)
        (irq_flag_o && irq_en) |-> irq_o);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (count_o == '0 && pwm_o == '0));

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        a_r3_rise_on_set: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_o[g]) |->
                ($past(count_o) == $past(set_w_flat[g*CNT_W +: CNT_W]) &&
                 $past(count_o) != $past(clr_w_flat[g*CNT_W +: CNT_W])));

        a_r4_fall_on_clr: assert property (@(posedge clk) disable iff (rst)
            $fell(pwm_o[g]) |->
                ($past(count_o) == $past(clr_w_flat[g*CNT_W +: CNT_W]) || !$past(en)));
    end

endmodule

bind mpwm_timer mpwm_timer_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick_sel   (tick_sel),
    .irq_en     (irq_en),
    .irq_clr    (irq_clr),
    .count_o    (count_o),
    .pwm_o      (pwm_o),
    .irq_flag_o (irq_flag_o),
    .irq_o      (irq_o),
    .lim_w      (lim_w),
    .set_w_flat (set_w_flat),
    .clr_w_flat (clr_w_flat)
);

// File: tb/mpwm_timer_tb.sv
`timescale 1ns/1ps
module mpwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [1:0]  tick_sel = 2'b10;
    logic        ext_tick = 1'b0;
    logic [15:0] limit_i = '0;
    logic [63:0] set_i = '0;
    logic [63:0] clr_i = '0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] count_o;
    logic [3:0]  pwm_o;
    logic        irq_flag_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] exp_cnt;
    logic [15:0] w_lim;
    logic [63:0] w_set;
    logic [63:0] w_clr;
    logic [3:0]  exp_pwm;
    logic        exp_flag;

    always #4 clk = ~clk;

    mpwm_timer dut_i (
        .clk(clk), .rst(rst), .en(en), .tick_sel(tick_sel), .ext_tick(ext_tick),
        .limit_i(limit_i), .set_i(set_i), .clr_i(clr_i), .irq_en(irq_en),
        .irq_clr(irq_clr), .count_o(count_o), .pwm_o(pwm_o),
        .irq_flag_o(irq_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_cmp();
        for (int c = 0; c < 4; c++) begin
            if (exp_cnt == w_clr[c*16 +: 16])      exp_pwm[c] = 1'b0;
            else if (exp_cnt == w_set[c*16 +: 16]) exp_pwm[c] = 1'b1;
        end
    endtask

    task automatic model_tick();
        if (exp_cnt == w_lim) begin
            exp_cnt  = '0;
            w_lim    = limit_i;
            w_set    = set_i;
            w_clr    = clr_i;
            exp_flag = 1'b1;
        end else begin
            exp_cnt = exp_cnt + 1'b1;
        end
        model_cmp();
    endtask

    task automatic check_state(input string req);
        check({req, " count"}, 32'(count_o), 32'(exp_cnt));
        check({req, " pwm"}, 32'(pwm_o), 32'(exp_pwm));
        check({req, " flag"}, 32'(irq_flag_o), 32'(exp_flag));
    endtask

    task automatic start_run();
        en = 1'b1;
        w_lim = limit_i; w_set = set_i; w_clr = clr_i;
        exp_cnt = '0; exp_pwm = '0;
        @(negedge clk); @(negedge clk);
        model_cmp();
        check_state("R5 enable load");
    endtask

    task automatic ext_step(input string req);
        ext_tick = 1'b1;
        @(negedge clk) ext_tick = 1'b0;
        @(negedge clk);
        model_tick();
        check_state(req);
    endtask

    task automatic t_reset();
        check("R9 reset count", 32'(count_o), 0);
        check("R9 reset pwm", 32'(pwm_o), 0);
        check("R9 reset flag", 32'(irq_flag_o), 0);
        exp_flag = 1'b0;
    endtask

    task automatic t_waveforms();
        tick_sel = 2'b10;
        limit_i = 16'd7;
        set_i = {16'd0, 16'd3, 16'd4, 16'd2};
        clr_i = {16'd6, 16'd3, 16'd1, 16'd5};
        start_run();
        for (int i = 0; i < 20; i++) ext_step("R1 R3 R4 wave");
    endtask

    task automatic t_irq();
        irq_en = 1'b0; #1;
        check("R7 masked", 32'(irq_o), 0);
        irq_en = 1'b1; #1;
        check("R7 passed", 32'(irq_o), 32'(exp_flag));
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        exp_flag = 1'b0;
        check("R6 clear", 32'(irq_flag_o), 0);
        check("R7 cleared", 32'(irq_o), 0);
    endtask

    task automatic t_shadow();
        limit_i = 16'd4;
        set_i[15:0] = 16'd1;
        clr_i[15:0] = 16'd3;
        for (int i = 0; i < 12; i++) ext_step("R5 shadow");
    endtask

    task automatic t_set_wins();
        while (exp_cnt != w_lim) ext_step("R6 approach");
        irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        exp_flag = 1'b0;
        check("R6 cleared before wrap", 32'(irq_flag_o), 0);
        ext_tick = 1'b1; irq_clr = 1'b1;
        @(negedge clk) begin ext_tick = 1'b0; irq_clr = 1'b0; end
        @(negedge clk);
        model_tick();
        check_state("R6 set wins");
    endtask

    task automatic t_stopped();
        tick_sel = 2'b11;
        for (int i = 0; i < 5; i++) begin
            ext_tick = 1'b1;
            @(negedge clk) ext_tick = 1'b0;
            @(negedge clk);
        end
        check_state("R2 stopped");
        tick_sel = 2'b10;
        ext_step("R2 ext resumes");
    endtask

    task automatic t_disable();
        en = 1'b0;
        @(negedge clk);
        check("R8 count zero", 32'(count_o), 0);
        check("R8 pwm low", 32'(pwm_o), 0);
        repeat (3) @(negedge clk);
        check("R8 held zero", 32'(count_o), 0);
    endtask

    task automatic measure(input logic [1:0] sel, input int exp_gap, input string req);
        int gap;
        logic [15:0] prev;
        tick_sel = sel;
        limit_i = 16'd1000;
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        prev = count_o;
        for (int i = 0; i < 40 && count_o == prev; i++) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            prev = count_o;
            gap = 0;
            for (int i = 0; i < 40 && count_o == prev; i++) begin
                @(negedge clk);
                gap++;
            end
            check(req, 32'(gap), 32'(exp_gap));
            check({req, " step"}, 32'(count_o), 32'(prev + 16'd1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_waveforms();
        t_irq();
        t_shadow();
        t_set_wins();
        t_stopped();
        t_disable();
        measure(2'b00, 2, "R2 div2 gap");
        measure(2'b01, 16, "R2 div16 gap");
        en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule